// File: doc/BRIEF.md
# Priority Interrupt Controller with Mask

This block gathers level-sensitive interrupt request flags from a set of peripheral sources and decides which one, if any, is forwarded to the processor. Each source owns a 4-bit priority level held in a bank of programmable 16-bit level registers, and a mask bit held in a mask register that software sets and clears through two separate write-one addresses. Among the sources that are raised, unmasked and given a non-zero level, the one with the highest level wins; equal levels resolve in favour of the lowest source index.

The winner's level is compared with the processor's current mask level. Only a strictly greater level raises the processor request, which is presented together with an event code identifying the source and the winning level. Arbitration and comparison are registered, so outputs follow inputs by one clock. Losing requests are not stored or cleared here: they stay visible for as long as their source keeps its flag raised and win as soon as the stronger request goes away.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset, `cpu_irq`, `irq_code` and `irq_level` are 0, every level field reads 0 and every mask bit reads 1 (all sources masked).
- R2: Source n takes its level from register address n/4, bits [4*(n%4)+3 : 4*(n%4)]; a write to that address is read back unchanged one cycle after `rd_addr` selects it.
- R3: A source whose level field is 0 never wins arbitration, whatever its flag.
- R4: Among eligible raised sources (flag high, mask bit 0, level non-zero) the highest level wins; a losing source that is still raised wins once the stronger one drops.
- R5: Eligible sources with the same level resolve to the lowest source index.
- R6: `cpu_irq` is 1 only if the winner's level is strictly greater than `cpu_imask`; an equal level gives no request.
- R7: While `cpu_irq` is 1, `irq_code` equals 0x200 + 0x20*n for winning source n and `irq_level` equals its level; while `cpu_irq` is 0 both are 0.
- R8: Writing to address 4 sets each mask bit whose data bit is 1 and leaves the others; a masked source never wins. Address 4 and 5 both read back the mask.
- R9: Writing to address 5 clears each mask bit whose data bit is 1; data bits that are 0 leave their mask bits unchanged.
- R10: Outputs reflect the flags, mask level and registers sampled at the previous rising edge: a request appears one cycle after its flag rises and disappears one cycle after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0..2 level registers, 4 mask set, 5 mask clear |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 16 | Registered read data |
| irq_src | input | 10 | Raised request flag per source |
| cpu_imask | input | 4 | Processor's current mask level |
| cpu_irq | output | 1 | Request to the processor |
| irq_code | output | 12 | Event code of the accepted source |
| irq_level | output | 4 | Level of the accepted source |

## Verification
The hardest situation to reach is a winner whose level equals the mask level exactly while a weaker source is also raised, since it must yield no request rather than fall through to the weaker one. Directed cases pin the mask at the winner's level and one below, then hand over from a dropped winner to a pending loser. Random flag, mask-level and register writes from a fixed seed then cover ties and masked combinations against a bench model of the register bank.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int LVL_W      = 4;
  localparam int REG_W      = 16;
  localparam int FLD_PER_RG = REG_W / LVL_W;
  localparam int ADDR_W     = 3;
  localparam int CODE_W     = 12;
  localparam logic [ADDR_W-1:0] ADR_MSET = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MCLR = 3'd5;
  localparam logic [CODE_W-1:0] CODE_BASE = 12'h200;
  localparam logic [CODE_W-1:0] CODE_STEP = 12'h020;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [REG_W-1:0]         rd_data,
  output logic [NUM_SRC*LVL_W-1:0] src_lvl,
  output logic [NUM_SRC-1:0]       src_mask
);
  localparam int NREG = (NUM_SRC + FLD_PER_RG - 1) / FLD_PER_RG;

  logic [REG_W-1:0] lvl_q [NREG];
  logic             past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) lvl_q[r] <= '0;
      src_mask <= '1;
      past_ok  <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (wr_en) begin
        for (int r = 0; r < NREG; r++)
          if (wr_addr == ADDR_W'(r)) lvl_q[r] <= wr_data;
        if (wr_addr == ADR_MSET) src_mask <= src_mask | wr_data[NUM_SRC-1:0];
        if (wr_addr == ADR_MCLR) src_mask <= src_mask & ~wr_data[NUM_SRC-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int r = 0; r < NREG; r++)
        if (rd_addr == ADDR_W'(r)) rd_data <= lvl_q[r];
      if (rd_addr == ADR_MSET || rd_addr == ADR_MCLR)
        rd_data <= REG_W'(src_mask);
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_fld
    assign src_lvl[n*LVL_W +: LVL_W] = lvl_q[n/FLD_PER_RG][(n%FLD_PER_RG)*LVL_W +: LVL_W];
  end

  // R9: a clear write leaves no selected mask bit set
  p_mask_clear_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (wr_en && wr_addr == ADR_MCLR) |=> ((src_mask & $past(wr_data[NUM_SRC-1:0])) == '0));
  // R8: a set write leaves every selected mask bit set
  p_mask_set_r8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (wr_en && wr_addr == ADR_MSET) |=> ((src_mask & $past(wr_data[NUM_SRC-1:0])) == $past(wr_data[NUM_SRC-1:0])));
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       req,
  input  logic [NUM_SRC-1:0]       mask,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx,
  output lvl_t                     win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !mask[i] && lvl[i*LVL_W +: LVL_W] > win_lvl) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_SRC-1:0]  irq_src,
  input  logic [LVL_W-1:0]    cpu_imask,
  output logic                cpu_irq,
  output logic [CODE_W-1:0]   irq_code,
  output logic [LVL_W-1:0]    irq_level
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC*LVL_W-1:0] src_lvl;
  logic [NUM_SRC-1:0]       src_mask;
  logic                     win_valid;
  logic [IDX_W-1:0]         win_idx;
  lvl_t                     win_lvl;
  logic                     accept;
  logic                     past_ok;

  prio_intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_lvl(src_lvl), .src_mask(src_mask)
  );

  prio_intc_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req(irq_src), .mask(src_mask), .lvl(src_lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign accept = win_valid && (win_lvl > cpu_imask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      irq_code  <= '0;
      irq_level <= '0;
      past_ok   <= 1'b0;
    end else begin
      past_ok   <= 1'b1;
      cpu_irq   <= accept;
      irq_code  <= accept ? CODE_BASE + CODE_STEP * CODE_W'(win_idx) : '0;
      irq_level <= accept ? win_lvl : '0;
    end
  end

  // R6: a request always carries a level above the mask seen one edge earlier
  p_above_mask_r6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    cpu_irq |-> (irq_level > $past(cpu_imask)));
  // R7: idle outputs are zero, active codes sit on the 0x20 grid from 0x200
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !cpu_irq |-> (irq_code == '0 && irq_level == '0));
  p_code_grid_r7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    cpu_irq |-> (irq_code[4:0] == 5'd0 && irq_code >= CODE_BASE));
  // R3 / R8: the winner is raised, unmasked and has a non-zero level
  p_win_eligible_r3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    win_valid |-> (irq_src[win_idx] && !src_mask[win_idx] && win_lvl != '0));
  // R10: a request follows a raised eligible source at the previous edge
  p_latency_r10: assert property (@(posedge clk) disable iff (rst || !past_ok)
    cpu_irq |-> $past(win_valid));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [NSRC-1:0] irq_src;
  logic [3:0]  cpu_imask;
  logic        cpu_irq;
  logic [11:0] irq_code;
  logic [3:0]  irq_level;

  int checks = 0;
  int errors = 0;
  logic [3:0]      m_lvl [NSRC];
  logic [NSRC-1:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_src(irq_src), .cpu_imask(cpu_imask),
    .cpu_irq(cpu_irq), .irq_code(irq_code), .irq_level(irq_level)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void model(input logic [NSRC-1:0] s, input logic [3:0] im,
                                output logic irq, output logic [11:0] code, output logic [3:0] lv);
    logic [3:0] best = 0;
    int idx = 0;
    for (int i = 0; i < NSRC; i++)
      if (s[i] && !m_mask[i] && m_lvl[i] > best) begin best = m_lvl[i]; idx = i; end
    irq  = (best != 0) && (best > im);
    code = irq ? 12'(32'h200 + 32'h20 * idx) : 12'h0;
    lv   = irq ? best : 4'h0;
  endfunction

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
    if (a < 3)
      for (int n = 0; n < NSRC; n++)
        if (n / 4 == a) m_lvl[n] = d[(n%4)*4 +: 4];
    if (a == 3'd4) m_mask = m_mask | d[NSRC-1:0];
    if (a == 3'd5) m_mask = m_mask & ~d[NSRC-1:0];
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
    rd_addr = a;
    step();
    check(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic apply_chk(string req, logic [NSRC-1:0] s, logic [3:0] im);
    logic e_irq; logic [11:0] e_code; logic [3:0] e_lv;
    irq_src = s; cpu_imask = im;
    step();
    model(s, im, e_irq, e_code, e_lv);
    check(req, 32'(cpu_irq), 32'(e_irq));
    check(req, 32'(irq_code), 32'(e_code));
    check(req, 32'(irq_level), 32'(e_lv));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    irq_src = '0; cpu_imask = '0;
    for (int n = 0; n < NSRC; n++) m_lvl[n] = '0;
    m_mask = '1;
    step(); step();
    rst = 1'b0;
    // R1: reset state
    check("R1", 32'(cpu_irq), 0);
    check("R1", 32'(irq_code), 0);
    check("R1", 32'(irq_level), 0);
    rd_chk("R1", 3'd4, 16'h03FF);
    rd_chk("R1", 3'd1, 16'h0000);
    // R2: level fields and readback
    wr(3'd0, 16'h4321);
    wr(3'd1, 16'h0765);
    wr(3'd2, 16'h0053);
    rd_chk("R2", 3'd1, 16'h0765);
    rd_chk("R2", 3'd2, 16'h0053);
    // R8: all masked after reset
    apply_chk("R8", 10'h3FF, 4'd0);
    // R9: clear all masks
    wr(3'd5, 16'h03FF);
    rd_chk("R9", 3'd5, 16'h0000);
    // R4 / R7: src6 level 7 wins, code 0x2C0
    apply_chk("R4", 10'h3FF, 4'd0);
    check("R7", 32'(irq_code), 32'h2C0);
    // R3: src7 has level 0
    apply_chk("R3", 10'h080, 4'd0);
    check("R3", 32'(cpu_irq), 0);
    // R5: src2 and src8 both level 3, src2 wins
    apply_chk("R5", 10'h104, 4'd0);
    check("R5", 32'(irq_code), 32'h240);
    // R6: equal level not accepted, one below accepted
    apply_chk("R6", 10'h040, 4'd7);
    check("R6", 32'(cpu_irq), 0);
    apply_chk("R6", 10'h040, 4'd6);
    check("R6", 32'(cpu_irq), 1);
    // R6: equal winner blocks even with a weaker source raised
    apply_chk("R6", 10'h060, 4'd7);
    check("R6", 32'(cpu_irq), 0);
    // R4: loser stays pending and wins after the stronger one drops
    apply_chk("R4", 10'h060, 4'd0);
    apply_chk("R4", 10'h020, 4'd0);
    check("R4", 32'(irq_code), 32'h2A0);
    // R10: one-cycle latency on rise and fall
    irq_src = '0; step();
    irq_src = 10'h040; #1;
    check("R10", 32'(cpu_irq), 0);
    step();
    check("R10", 32'(cpu_irq), 1);
    irq_src = '0; #1;
    check("R10", 32'(cpu_irq), 1);
    step();
    check("R10", 32'(cpu_irq), 0);
    // R8: set mask on src6, zero bits untouched
    wr(3'd4, 16'h0040);
    apply_chk("R8", 10'h060, 4'd0);
    check("R8", 32'(irq_code), 32'h2A0);
    rd_chk("R8", 3'd4, 16'h0040);
    // R9: clearing with zero data changes nothing
    wr(3'd5, 16'h0000);
    rd_chk("R9", 3'd5, 16'h0040);
    apply_chk("R9", 10'h060, 4'd0);
    // random mix
    for (int it = 0; it < 500; it++) begin
      if ($urandom % 6 == 0) begin
        case ($urandom % 3)
          0: wr(3'($urandom % 3), 16'($urandom));
          1: wr(3'd4, 16'($urandom) & 16'($urandom));
          default: wr(3'd5, 16'($urandom));
        endcase
      end
      apply_chk("R4", NSRC'($urandom), 4'($urandom % 8));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule